// File: doc/BRIEF.md
# Scanline Interrupt Timer with Mirroring Control

This block raises a CPU interrupt after a programmed number of video scanlines. Software writes a start value into a holding latch and copies it into an up-counter. It then arms the timer. From then on, every pulse on the scanline input moves the counter up by one. The step that carries the counter from 0xFF to 0x100 raises the interrupt line and disarms the timer on its own. The timer therefore fires once per arming. The interrupt stays raised until software writes the acknowledge register, which also disarms the timer. The same write port also sets a single mirroring-select bit that feeds the video memory mapping.

Writes are decoded inside the 0xC000–0xFFFF window. The address is ANDed with 0xF003 first, so every register appears at several aliases. The scanline pulse is generated elsewhere. The block only consumes it.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset, irqOut and mirrorSel are 0, and the latch, counter and armed flag hold 0. Arming straight after reset therefore fires on the 256th scanline pulse.
- R2: A write takes effect only when (wrAddr & 0xF003) equals 0xC000, 0xC001, 0xC002, 0xC003 or 0xE000. Any other address has no effect. Aliases such as 0xC004, which masks to 0xC000, behave exactly like the base address.
- R3: A write to 0xC000 stores wrData in the 8-bit latch.
- R4: A write to 0xC001 loads the counter with the latch value, zero-extended to 9 bits.
- R5: A write to 0xC002 arms the timer.
- R6: A write to 0xC003 disarms the timer and drives irqOut low on the next cycle.
- R7: A write to 0xE000 sets mirrorSel to the inverse of wrData bit 6.
- R8: A scanline pulse while armed adds one to the counter. A pulse while disarmed changes nothing.
- R9: The pulse that brings the counter to 0x100 sets irqOut and disarms the timer in the same cycle. Later pulses do not move the counter until the timer is armed again.
- R10: Once set, irqOut stays high until a write to 0xC003 or a reset. A write to 0xC002 does not clear it.
- R11: When a decoded register write and a scanline pulse arrive in the same cycle, the write is applied and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe, one cycle per write |
| wrAddr | input | 16 | CPU write address |
| wrData | input | 8 | CPU write data |
| lineTick | input | 1 | One-cycle pulse per scanline |
| irqOut | output | 1 | Interrupt request, active high |
| mirrorSel | output | 1 | Mirroring-select bit |

## Verification
The bench sweeps every one of the 256 latch values. For each one it checks that the interrupt stays low on the pulse before overflow and rises exactly on the overflow pulse. A comparison at the wrong width, or a reload that is off by one, would fire one pulse early or late for some start values. Other tests check that a pulse landing on the same cycle as a write is dropped, so a design that let it through would fire one line early. They also check that the timer stays disarmed after it fires, so a design that forgot to clear the armed flag would keep counting and could wrap around to fire again. Masked aliases and undecoded addresses are written with data that would visibly change the mirroring bit or arm the timer, which catches any design that decodes too loosely or too tightly.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

  // Write strobes produced by the decoder, one per register function,
  // plus the qualified scanline advance.
  typedef struct packed {
    logic loadLatch;
    logic reloadCount;
    logic setEnable;
    logic clearEnable;
    logic setMirror;
    logic tick;
  } ctrlStrobes_t;

endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ADDR_MASK   = 16'hF003,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 16'hC000,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 16'hC001,
  parameter logic [ADDR_W-1:0] ARM_ADDR    = 16'hC002,
  parameter logic [ADDR_W-1:0] ACK_ADDR    = 16'hC003,
  parameter logic [ADDR_W-1:0] MIRROR_ADDR = 16'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              lineTick,
  output ctrlStrobes_t      strobes
);

  logic [ADDR_W-1:0] maskedAddr;
  logic              regHit;

  always_comb begin
    maskedAddr          = wrAddr & ADDR_MASK;
    strobes             = '0;
    strobes.loadLatch   = wrEn && (maskedAddr == LATCH_ADDR);
    strobes.reloadCount = wrEn && (maskedAddr == RELOAD_ADDR);
    strobes.setEnable   = wrEn && (maskedAddr == ARM_ADDR);
    strobes.clearEnable = wrEn && (maskedAddr == ACK_ADDR);
    strobes.setMirror   = wrEn && (maskedAddr == MIRROR_ADDR);
    regHit = strobes.loadLatch | strobes.reloadCount | strobes.setEnable
           | strobes.clearEnable | strobes.setMirror;
    // a register write wins over a scanline pulse in the same cycle
    strobes.tick = lineTick && !regHit;
  end

  // R2
  one_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.loadLatch, strobes.reloadCount, strobes.setEnable,
              strobes.clearEnable, strobes.setMirror}));

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && lineTick && ((wrAddr & ADDR_MASK) == ARM_ADDR)) |-> !strobes.tick);

endmodule

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import scanline_irq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIRROR_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqOut,
  output logic              mirrorSel
);

  localparam int CNT_W = DATA_W + 1;
  localparam logic [CNT_W-1:0] FIRE_VAL = CNT_W'(1) << DATA_W;

  logic [DATA_W-1:0] latchQ;
  logic [CNT_W-1:0]  countQ, countNext;
  logic              enQ, irqQ, mirrorQ;

  always_comb countNext = countQ + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchQ  <= '0;
      countQ  <= '0;
      enQ     <= 1'b0;
      irqQ    <= 1'b0;
      mirrorQ <= 1'b0;
    end else begin
      if (strobes.loadLatch)   latchQ  <= wrData;
      if (strobes.setMirror)   mirrorQ <= ~wrData[MIRROR_BIT];
      if (strobes.reloadCount) countQ  <= {1'b0, latchQ};
      if (strobes.setEnable)   enQ     <= 1'b1;
      if (strobes.clearEnable) begin
        enQ  <= 1'b0;
        irqQ <= 1'b0;
      end
      if (strobes.tick && enQ) begin
        countQ <= countNext;
        if (countNext == FIRE_VAL) begin
          irqQ <= 1'b1;
          enQ  <= 1'b0;
        end
      end
    end
  end

  assign irqOut    = irqQ;
  assign mirrorSel = mirrorQ;

  // R9
  fire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqQ) |-> (!enQ && countQ == FIRE_VAL));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearEnable |=> (!irqQ && !enQ));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqQ && !strobes.clearEnable) |=> irqQ);

  // R8
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.reloadCount && !(strobes.tick && enQ)) |=> $stable(countQ));

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
  import scanline_irq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lineTick,
  output logic              irqOut,
  output logic              mirrorSel
);

  ctrlStrobes_t strobes;

  sirq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .lineTick (lineTick),
    .strobes  (strobes)
  );

  sirq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wrData    (wrData),
    .irqOut    (irqOut),
    .mirrorSel (mirrorSel)
  );

endmodule

// File: tb/scanline_irq_timer_test.sv
module scanline_irq_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        lineTick = 1'b0;
  logic        irqOut, mirrorSel;

  int vecCount = 0;
  int errCount = 0;
  bit finished = 0;

  // reference state built from the requirements
  int mLatch, mCount;
  bit mEn, mIrq, mMirror;

  always #5 clk = ~clk;

  scanline_irq_timer uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .lineTick(lineTick),
    .irqOut(irqOut), .mirrorSel(mirrorSel)
  );

  function automatic void modelWrite(input logic [15:0] a, input logic [7:0] d);
    case (a & 16'hF003)
      16'hC000: mLatch = d;
      16'hC001: mCount = mLatch;
      16'hC002: mEn = 1;
      16'hC003: begin mEn = 0; mIrq = 0; end
      16'hE000: mMirror = !d[6];
      default: ;
    endcase
  endfunction

  function automatic void modelTick();
    if (mEn) begin
      mCount = (mCount + 1) % 512;
      if (mCount == 256) begin mIrq = 1; mEn = 0; end
    end
  endfunction

  function automatic bit isReg(input logic [15:0] a);
    logic [15:0] m;
    m = a & 16'hF003;
    return m == 16'hC000 || m == 16'hC001 || m == 16'hC002 ||
           m == 16'hC003 || m == 16'hE000;
  endfunction

  // inputs change on the falling edge; results are sampled one falling edge later
  task automatic cycle(input bit we, input logic [15:0] a, input logic [7:0] d, input bit tk);
    wrEn = we; wrAddr = a; wrData = d; lineTick = tk;
    if (we) modelWrite(a, d);
    if (tk && !(we && isReg(a))) modelTick();
    @(negedge clk);
    wrEn = 0; lineTick = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cycle(1, a, d, 0);
  endtask

  task automatic tick();
    cycle(0, 16'h0, 8'h0, 1);
  endtask

  task automatic cmp(input string req);
    vecCount++;
    if (irqOut !== mIrq || mirrorSel !== mMirror) begin
      errCount++;
      $display("FAIL %s: irq=%0b mirror=%0b expected irq=%0b mirror=%0b",
               req, irqOut, mirrorSel, mIrq, mMirror);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    errCount++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish();
  end

  initial begin
    mLatch = 0; mCount = 0; mEn = 0; mIrq = 0; mMirror = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 reset");

    // R1: counter starts at zero, so arming fires on the 256th pulse
    wr(16'hC002, 8'h00);
    for (int i = 0; i < 255; i++) tick();
    cmp("R1 no fire before 256 pulses");
    tick();
    cmp("R1 fire on 256th pulse");

    // R10: arming again does not drop the request
    wr(16'hC002, 8'h00);
    cmp("R10 arm keeps irq");
    tick(); tick();
    cmp("R10 irq held across pulses");
    wr(16'hC003, 8'h00);
    cmp("R6 ack clears irq");

    // R7: mirroring follows inverted bit 6
    wr(16'hE000, 8'h40); cmp("R7 bit6=1");
    wr(16'hE000, 8'hBF); cmp("R7 bit6=0");
    wr(16'hE000, 8'h40); cmp("R7 bit6=1 again");

    // R2: undecoded addresses leave state untouched
    wr(16'hE001, 8'h00); cmp("R2 E001 ignored");
    wr(16'hF000, 8'h00); cmp("R2 F000 ignored");
    wr(16'h8000, 8'h00); cmp("R2 8000 ignored");
    wr(16'hD002, 8'h00);
    for (int i = 0; i < 300; i++) tick();
    cmp("R2 D002 does not arm");
    // R2: alias 0xE004 masks to 0xE000
    wr(16'hE004, 8'h00); cmp("R2 E004 alias mirror");
    // R2: alias 0xC004 masks to 0xC000, 0xC005 to 0xC001, 0xD00A? not decoded
    wr(16'hC004, 8'hFE);
    wr(16'hC005, 8'h00);
    wr(16'hC006, 8'h00);
    tick(); cmp("R2 alias one pulse");
    tick(); cmp("R2 alias fire");
    wr(16'hC007, 8'h00); cmp("R2 alias ack");

    // R8: pulses while disarmed do not move the counter
    wr(16'hC000, 8'hF0); wr(16'hC001, 8'h00);
    for (int i = 0; i < 40; i++) tick();
    wr(16'hC002, 8'h00);
    for (int i = 0; i < 15; i++) tick();
    cmp("R8 disarmed pulses ignored, no fire at 15");
    tick(); cmp("R8 fire at 16");
    // R9: one-shot; further pulses do not advance the counter
    wr(16'hC003, 8'h00);
    wr(16'hC002, 8'h00);
    for (int i = 0; i < 255; i++) tick();
    cmp("R9 counter held at 0x100 after fire");
    tick();
    cmp("R9 rearm without reload");
    wr(16'hC003, 8'h00);

    // R11: pulses that coincide with a register write are dropped
    wr(16'hC000, 8'hFD); wr(16'hC001, 8'h00);
    cycle(1, 16'hC002, 8'h00, 1);
    cmp("R11 arm write with pulse");
    cycle(1, 16'hE000, 8'h00, 1);
    cycle(1, 16'hC000, 8'h10, 1);
    tick(); tick();
    cmp("R11 two pulses after dropped ones");
    tick();
    cmp("R11 fire on third counted pulse");
    wr(16'hC003, 8'h00);

    // R3 R4 R5 R9: sweep every latch value
    for (int v = 0; v < 256; v++) begin
      wr(16'hC000, 8'(v));
      wr(16'hC001, 8'h00);
      wr(16'hC002, 8'h00);
      for (int i = 0; i < 255 - v; i++) tick();
      cmp("R4 sweep before overflow");
      tick();
      cmp("R9 sweep overflow");
      wr(16'hC003, 8'h00);
    end

    // R1: reset mid-operation clears everything
    wr(16'hC000, 8'hFF); wr(16'hC001, 8'h00); wr(16'hC002, 8'h00); tick();
    rst_n = 0;
    mLatch = 0; mCount = 0; mEn = 0; mIrq = 0; mMirror = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 reset after fire");

    finish();
  end

endmodule